// File: doc/BRIEF.md
# Bus Request Legality Guard

This block sits at the front of a small register-mapped peripheral and screens every request arriving on a TL-UL A channel. A request that breaks the generic TL-UL rules (opcode, size, alignment, byte mask) or the device's own rules (unmapped word, misaligned register write, write narrower than the register) is blocked and answered on the D channel with the error flag set. A legal request is forwarded, in the same cycle it is accepted, as a single-cycle register request with a write enable, a word index, byte enables and write data. Read data comes back combinationally from the register file in that cycle.

Only one transaction is in flight at a time. The response is registered and held until the host accepts it; no new request is taken while a response waits. The register map is `NREG` words. The byte width of each word is set by the packed parameter `REG_WBYTES`, which holds width-minus-one for each word. Word 0 sits in the lowest field. The default widths, word 0 to 5, are 4, 1, 2, 4, 3 and 4 bytes.

Top module: `bus_req_guard`

## Requirements
- R1: Only opcodes Get (4), PutFullData (0) and PutPartialData (1) are legal; any other opcode is answered with an error. The response opcode is 1 (AccessAckData) for a Get request and 0 (AccessAck) for every other request.
- R2: A size field larger than 2 (for 32-bit data) is an error. An address whose low bits are not a multiple of 2^size is also an error.
- R3: Lane l lies in the access window when l>>size equals addr[1:0]>>size. Any set mask bit outside the window is an error, for example address 0x00, size 0, mask 0b0010, or address 0x01, mask 0b0001.
- R4: A PutFullData request whose mask does not equal its access window exactly is an error.
- R5: A word index addr[7:2] of NREG or more is unmapped. With dev_mode_i=1 it is answered with an error. With dev_mode_i=0 it gets no error, is not forwarded, and a read returns zero data.
- R6: A write to a mapped word with addr[1:0] not zero is an error. A write to a mapped word whose mask leaves any of the word's low W lanes clear, where W is the word's byte width, is an error.
- R7: A legal mapped request is forwarded in its acceptance cycle with reg_we_o=1 for puts, reg_idx_o=addr[7:2], reg_be_o=mask and reg_wdata_o=data. A rejected request produces no register request, so no register can change.
- R8: While a response is pending (d_valid_o=1), a_ready_o is 0 and no request is forwarded, even for a repeat of the same address.
- R9: d_opcode_o, d_size_o, d_source_o, d_error_o and d_data_o stay stable while d_valid_o=1 and d_ready_i=0. d_size_o and d_source_o echo the request. d_valid_o falls in the cycle after d_ready_i is seen high.
- R10: A legal mapped Get returns the full register word whatever its mask. An errored response, and any response to a write, carries zero data.
- R11: After reset d_valid_o is 0 and a_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_mode_i | input | 1 | Strap: 1 makes unmapped accesses error |
| a_valid_i | input | 1 | A-channel valid |
| a_ready_o | output | 1 | A-channel ready |
| a_opcode_i | input | 3 | A-channel opcode |
| a_size_i | input | 2 | log2 of access bytes |
| a_source_i | input | SW | Request source tag |
| a_address_i | input | AW | Byte address |
| a_mask_i | input | DW/8 | Byte lane mask |
| a_data_i | input | DW | Write data |
| d_valid_o | output | 1 | D-channel valid |
| d_ready_i | input | 1 | D-channel ready |
| d_opcode_o | output | 3 | Response opcode |
| d_size_o | output | 2 | Echoed size |
| d_source_o | output | SW | Echoed source |
| d_error_o | output | 1 | Error flag |
| d_data_o | output | DW | Read data |
| reg_req_o | output | 1 | Register access strobe |
| reg_we_o | output | 1 | Register write enable |
| reg_idx_o | output | AW-2 | Register word index |
| reg_be_o | output | DW/8 | Register byte enables |
| reg_wdata_o | output | DW | Register write data |
| reg_rdata_i | input | DW | Register read data |

## Verification
The only internal state is the registered response. If it is wrong, the port shows it on the first cycle d_valid_o is high. It may show as a wrong error flag or opcode, or as stale data from a previous access. It may also show as a field that moves while the host stalls d_ready_i, or as a_ready_o reopening one cycle early or late. A wrong legality decision shows in the acceptance cycle itself, as a register strobe that should or should not be there. The sweep covers every opcode, size, low address offset, mask and strap value over mapped words of each width and over unmapped words.

// File: rtl/bus_req_guard.sv
module bus_req_guard #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SW = 4,
  parameter int NREG = 6,
  parameter logic [2*NREG-1:0] REG_WBYTES = 12'hED3,
  localparam int NB = DW / 8,
  localparam int OFFW = $clog2(NB),
  localparam int IW = AW - OFFW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_mode_i,
  input  logic          a_valid_i,
  output logic          a_ready_o,
  input  logic [2:0]    a_opcode_i,
  input  logic [1:0]    a_size_i,
  input  logic [SW-1:0] a_source_i,
  input  logic [AW-1:0] a_address_i,
  input  logic [NB-1:0] a_mask_i,
  input  logic [DW-1:0] a_data_i,
  output logic          d_valid_o,
  input  logic          d_ready_i,
  output logic [2:0]    d_opcode_o,
  output logic [1:0]    d_size_o,
  output logic [SW-1:0] d_source_o,
  output logic          d_error_o,
  output logic [DW-1:0] d_data_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [IW-1:0] reg_idx_o,
  output logic [NB-1:0] reg_be_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam logic [2:0] OP_PUTF = 3'd0;
  localparam logic [2:0] OP_PUTP = 3'd1;
  localparam logic [2:0] OP_GET  = 3'd4;

  logic [OFFW-1:0] off;
  logic [IW-1:0]   idx;
  logic [NB-1:0]   win, need;
  logic [OFFW:0]   wbytes;
  logic            accept, is_wr, mapped, err;

  assign off    = a_address_i[OFFW-1:0];
  assign idx    = a_address_i[AW-1:OFFW];
  assign is_wr  = (a_opcode_i == OP_PUTF) || (a_opcode_i == OP_PUTP);
  assign mapped = int'(idx) < NREG;
  assign accept = a_valid_i && a_ready_o;
  assign a_ready_o = !d_valid_o;

  always_comb begin
    wbytes = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(idx) == i)
        wbytes = (OFFW+1)'(REG_WBYTES[OFFW*i +: OFFW]) + (OFFW+1)'(1);
    for (int l = 0; l < NB; l++) begin
      win[l]  = ((l >> a_size_i) == (int'(off) >> a_size_i));
      need[l] = l < int'(wbytes);
    end
  end

  always_comb begin
    err = 1'b0;
    if (!(is_wr || a_opcode_i == OP_GET))                err = 1'b1;
    if (int'(a_size_i) > OFFW)                            err = 1'b1;
    if ((int'(off) & ((1 << a_size_i) - 1)) != 0)         err = 1'b1;
    if (|(a_mask_i & ~win))                               err = 1'b1;
    if (a_opcode_i == OP_PUTF && a_mask_i != win)         err = 1'b1;
    if (!mapped && dev_mode_i)                            err = 1'b1;
    if (is_wr && mapped && off != '0)                     err = 1'b1;
    if (is_wr && mapped && |(need & ~a_mask_i))           err = 1'b1;
  end

  assign reg_req_o   = accept && !err && mapped;
  assign reg_we_o    = is_wr;
  assign reg_idx_o   = idx;
  assign reg_be_o    = a_mask_i;
  assign reg_wdata_o = a_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= '0;
      d_size_o   <= '0;
      d_source_o <= '0;
      d_error_o  <= 1'b0;
      d_data_o   <= '0;
    end else if (accept) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= (a_opcode_i == OP_GET) ? 3'd1 : 3'd0;
      d_size_o   <= a_size_i;
      d_source_o <= a_source_i;
      d_error_o  <= err;
      d_data_o   <= (a_opcode_i == OP_GET && !err && mapped) ? reg_rdata_i : '0;
    end else if (d_ready_i) begin
      d_valid_o  <= 1'b0;
    end
  end

  // R2
  size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_i && a_ready_o && int'(a_size_i) > OFFW |=> d_valid_o && d_error_o);

  // R4
  putfull_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_i && a_ready_o && a_opcode_i == OP_PUTF && a_size_i == 2'(OFFW)
    && a_mask_i != '1 |=> d_error_o);

  // R7
  fwd_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> d_valid_o && !d_error_o);

  // R8
  one_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o |-> !reg_req_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && !d_ready_i |=> d_valid_o && $stable(d_data_o) && $stable(d_error_o)
    && $stable(d_opcode_o) && $stable(d_source_o) && $stable(d_size_o));

  // R10
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o && d_error_o |-> d_data_o == '0);
endmodule

// File: tb/bus_req_guard_tb_top.sv
module bus_req_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 6;
  localparam int WB [NREG] = '{4, 1, 2, 4, 3, 4};

  logic clk = 0, rst_n = 0, dev_mode = 0;
  logic a_valid = 0, a_ready, d_valid, d_ready = 0, d_error;
  logic [2:0] a_opcode = 0, d_opcode;
  logic [1:0] a_size = 0, d_size;
  logic [3:0] a_source = 0, d_source, a_mask = 0, reg_be;
  logic [7:0] a_address = 0;
  logic [31:0] a_data = 0, d_data, reg_wdata, reg_rdata;
  logic reg_req, reg_we;
  logic [5:0] reg_idx;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign reg_rdata = 32'h8C41_0000 + 32'(reg_idx) * 32'h0000_1111;

  bus_req_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_mode_i(dev_mode),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_opcode_i(a_opcode),
    .a_size_i(a_size), .a_source_i(a_source), .a_address_i(a_address),
    .a_mask_i(a_mask), .a_data_i(a_data),
    .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode),
    .d_size_o(d_size), .d_source_o(d_source), .d_error_o(d_error),
    .d_data_o(d_data),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_idx_o(reg_idx),
    .reg_be_o(reg_be), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 20) $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      check(0, "watchdog", 64'(cycles), 64'd150000);
      finish_run();
    end
  end

  initial begin
    int n = 0;
    int words [5] = '{0, 1, 2, 4, 6};
    #(3*CLK_PERIOD + 2);
    check(d_valid == 0, "R11", 64'(d_valid), 0);
    check(a_ready == 1, "R11", 64'(a_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check(d_valid == 0 && a_ready == 1, "R11", 64'({d_valid, a_ready}), 1);
    for (int dm = 0; dm < 2; dm++)
    for (int op = 0; op < 8; op++)
    for (int sz = 0; sz < 4; sz++)
    for (int w = 0; w < 5; w++)
    for (int of = 0; of < 4; of++)
    for (int mk = 0; mk < 16; mk++) begin
      int wi = words[w];
      bit op_ok, wr, mapped, e1, e2, e3, e4, e5, e6, err, fwd;
      logic [3:0] win, need;
      logic [31:0] exp_data;
      logic [2:0] exp_op;
      string tag;
      logic [31:0] s_data; logic [2:0] s_op; logic [1:0] s_sz; logic [3:0] s_src; logic s_err;
      n++;
      dev_mode = dm[0];
      a_opcode = 3'(op); a_size = 2'(sz); a_address = 8'(wi*4 + of);
      a_mask = 4'(mk); a_source = 4'(n); a_data = 32'h1357_9BDF ^ (32'(n) * 32'h0101_0103);
      a_valid = 1; d_ready = 0;
      op_ok = (op == 0 || op == 1 || op == 4);
      wr = (op == 0 || op == 1);
      mapped = wi < NREG;
      for (int l = 0; l < 4; l++) begin
        win[l] = ((l >> sz) == (of >> sz));
        need[l] = mapped && l < WB[mapped ? wi : 0];
      end
      e1 = !op_ok;
      e2 = sz > 2 || (of % (1 << sz)) != 0;
      e3 = (4'(mk) & ~win) != 0;
      e4 = op == 0 && 4'(mk) != win;
      e5 = !mapped && dm == 1;
      e6 = wr && mapped && (of != 0 || (need & ~4'(mk)) != 0);
      err = e1 || e2 || e3 || e4 || e5 || e6;
      fwd = !err && mapped;
      tag = e1 ? "R1" : e2 ? "R2" : e3 ? "R3" : e4 ? "R4" : e5 ? "R5" : e6 ? "R6" : "R7";
      exp_op = (op == 4) ? 3'd1 : 3'd0;
      exp_data = (op == 4 && fwd) ? 32'h8C41_0000 + 32'(wi) * 32'h0000_1111 : 32'h0;
      #1;
      check(a_ready == 1, "R8", 64'(a_ready), 1);
      check(reg_req == fwd, tag, 64'(reg_req), 64'(fwd));
      if (fwd) begin
        check(reg_we == wr && reg_idx == 6'(wi) && reg_be == 4'(mk) && reg_wdata == a_data,
              "R7", {reg_we, reg_idx, reg_be, reg_wdata}, {wr, 6'(wi), 4'(mk), a_data});
      end
      @(posedge clk); @(negedge clk);
      check(d_valid == 1, "R8", 64'(d_valid), 1);
      check(d_error == err, tag, 64'(d_error), 64'(err));
      check(d_opcode == exp_op, "R1", 64'(d_opcode), 64'(exp_op));
      check(d_size == 2'(sz) && d_source == 4'(n), "R9", {d_size, d_source}, {2'(sz), 4'(n)});
      check(d_data == exp_data, mapped ? "R10" : "R5", 64'(d_data), 64'(exp_data));
      check(a_ready == 0 && reg_req == 0, "R8", 64'({a_ready, reg_req}), 0);
      s_data = d_data; s_op = d_opcode; s_sz = d_size; s_src = d_source; s_err = d_error;
      a_source = ~a_source; a_size = ~a_size; a_opcode = 3'd4;
      @(posedge clk); @(negedge clk);
      check(d_valid == 1 && d_data == s_data && d_opcode == s_op && d_size == s_sz
            && d_source == s_src && d_error == s_err, "R9", {d_valid, d_data}, {1'b1, s_data});
      check(reg_req == 0, "R8", 64'(reg_req), 0);
      d_ready = 1; a_valid = 0;
      @(posedge clk); @(negedge clk);
      d_ready = 0;
      check(d_valid == 0 && a_ready == 1, "R9", 64'({d_valid, a_ready}), 1);
    end
    done = 1;
    finish_run();
  end
endmodule